// File: doc/BRIEF.md
# 64-bit Periodic Interval Timer

This block is a programmable interval timer with a 64-bit up-counter, reached over a simple 32-bit register bus with single-cycle accesses. A 4-bit divide field sets a prescaler, so the counter advances once every (field+1) peripheral clocks. The counter counts from zero up to a 64-bit period and then wraps to zero. On each wrap it emits a one-cycle pulse on `period_pulse`. In continuous mode it keeps running after the wrap. In one-shot mode it stops at zero after the first wrap. Programming both period words to all ones turns the block into a free-running 64-bit time base.

The run control is a two-state machine. In `ST_IDLE` the counter holds its value. In `ST_RUN` it advances on prescaler ticks. The transitions are:
- `IDLE->RUN` on a start strobe.
- `RUN->RUN` on a start strobe, which restarts the count from zero.
- `RUN->IDLE` on a software-reset strobe.
- `RUN->IDLE` on a wrap in one-shot mode.

A software-reset strobe does the following: it leaves or keeps `ST_IDLE`, it clears the counter and the prescaler, and it zeroes the mode and period registers. If start and software reset are written in the same access, software reset wins.

The counter is read as two live 32-bit halves that are not snapshotted. Software that needs a consistent 64-bit value reads the high half, then the low half, then the high half again. If the two high reads differ, a carry happened between them and software repeats the sequence.

Top module: `pit64_timer`

## Requirements
- R1: After reset every mapped register reads zero, the counter is stopped at zero and `period_pulse` is low.
- R2: Writing 1 to bit 0 of the control register (offset 0x00) starts counting from zero. The counter value read n clocks after the start edge is floor(n/(div+1)), until the first wrap.
- R3: The mode register (offset 0x04) holds the divide field in bits 11:8 and reads back as written. The counter advances only once every (field+1) clocks.
- R4: In continuous mode (mode bit 0 = 1), a tick that finds the count equal to the period sets the count to zero and counting goes on.
- R5: In one-shot mode (mode bit 0 = 0), the wrap to zero stops the counter. It then holds zero until the next start, and that start counts from zero again.
- R6: `period_pulse` is high for exactly the one clock that follows the wrap edge, and at no other time.
- R7: Writing 1 to bit 8 of the control register stops the counter, clears it, and zeroes the mode and period registers. It overrides a start bit written in the same access.
- R8: The control register reads zero. Offsets other than 0x04, 0x08, 0x0C, 0x20 and 0x24 read zero and ignore writes, and writes to the counter offsets change nothing.
- R9: The period low word (0x08) and high word (0x0C) read back as written. The counter low half (0x20) and high half (0x24) return the live count. Read data appears on `rdata` the clock after the `rd_en` edge, carrying the count as it stood just before that edge.
- R10: A period write made while running takes effect immediately and is compared from the next tick onward.
- R11: A start written while running restarts the count from zero without a stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| rd_en | input | 1 | Register read strobe, one cycle |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| period_pulse | output | 1 | One-cycle pulse on each counter wrap |

## Verification
The bench counts clocks from each start edge and predicts every counter read from the divide and period settings. This exposes an off-by-one in the prescaler (the count would run one step early or late) and a wrap at period-1 or period+1 (the read after the wrap would be non-zero). It pins the pulse to the exact clock after the wrap, so a pulse placed early, placed late or held for two clocks is caught. It reads one-shot mode long after the wrap, where a counter that fails to stop would show a growing value. It writes start and software reset together, where the wrong priority would leave the counter running. It lowers the period mid-run and expects the wrap at the new value. It writes to unmapped and counter offsets and reads back the neighbouring registers, where a loose address decode would corrupt mode or period.

// File: rtl/pit64_pkg.sv
package pit64_pkg;
    localparam int unsigned WORD_W     = 32;
    localparam int unsigned OFF_CTRL   = 32'h00;
    localparam int unsigned OFF_MODE   = 32'h04;
    localparam int unsigned OFF_PER_LO = 32'h08;
    localparam int unsigned OFF_PER_HI = 32'h0C;
    localparam int unsigned OFF_CNT_LO = 32'h20;
    localparam int unsigned OFF_CNT_HI = 32'h24;
    localparam int unsigned BIT_START  = 0;
    localparam int unsigned BIT_SWRST  = 8;
    localparam int unsigned BIT_CONT   = 0;
    localparam int unsigned BIT_DIV    = 8;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } run_state_e;
endpackage

// File: rtl/pit64_regs.sv
module pit64_regs
    import pit64_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned PRESC_W = 4,
    localparam int unsigned CNT_W  = 2 * WORD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic                rd_en,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [WORD_W-1:0]   wdata,
    input  logic [CNT_W-1:0]    count_i,
    output logic [WORD_W-1:0]   rdata,
    output logic                start_stb,
    output logic                swrst_stb,
    output logic                cont_o,
    output logic [PRESC_W-1:0]  div_o,
    output logic [CNT_W-1:0]    period_o
);
    logic               cont_q;
    logic [PRESC_W-1:0] div_q;
    logic [CNT_W-1:0]   period_q;
    logic [WORD_W-1:0]  mode_view;
    logic               sel_ctrl;

    assign sel_ctrl  = wr_en && (addr == ADDR_W'(OFF_CTRL));
    assign start_stb = sel_ctrl && wdata[BIT_START];
    assign swrst_stb = sel_ctrl && wdata[BIT_SWRST];

    always_comb begin
        mode_view = '0;
        mode_view[BIT_CONT] = cont_q;
        mode_view[BIT_DIV +: PRESC_W] = div_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cont_q   <= 1'b0;
            div_q    <= '0;
            period_q <= '0;
        end else if (swrst_stb) begin
            cont_q   <= 1'b0;
            div_q    <= '0;
            period_q <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(OFF_MODE)) begin
                cont_q <= wdata[BIT_CONT];
                div_q  <= wdata[BIT_DIV +: PRESC_W];
            end
            if (addr == ADDR_W'(OFF_PER_LO)) period_q[WORD_W-1:0]     <= wdata;
            if (addr == ADDR_W'(OFF_PER_HI)) period_q[CNT_W-1:WORD_W] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_en) begin
            if (addr == ADDR_W'(OFF_MODE))        rdata <= mode_view;
            else if (addr == ADDR_W'(OFF_PER_LO)) rdata <= period_q[WORD_W-1:0];
            else if (addr == ADDR_W'(OFF_PER_HI)) rdata <= period_q[CNT_W-1:WORD_W];
            else if (addr == ADDR_W'(OFF_CNT_LO)) rdata <= count_i[WORD_W-1:0];
            else if (addr == ADDR_W'(OFF_CNT_HI)) rdata <= count_i[CNT_W-1:WORD_W];
            else                                  rdata <= '0;
        end
    end

    assign cont_o   = cont_q;
    assign div_o    = div_q;
    assign period_o = period_q;
endmodule

// File: rtl/pit64_prescaler.sv
module pit64_prescaler #(
    parameter int unsigned PRESC_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clr,
    input  logic               en,
    input  logic [PRESC_W-1:0] div,
    output logic               tick
);
    logic [PRESC_W-1:0] pre_q;

    assign tick = en && (pre_q >= div);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pre_q <= '0;
        else if (clr) pre_q <= '0;
        else if (en)  pre_q <= tick ? '0 : pre_q + PRESC_W'(1);
    end
endmodule

// File: rtl/pit64_core.sv
module pit64_core
    import pit64_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_stb,
    input  logic             swrst_stb,
    input  logic             tick,
    input  logic             cont,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count_o,
    output logic             running_o,
    output logic             pulse_o
);
    run_state_e       state_q, state_d;
    logic [CNT_W-1:0] count_q;
    logic             pulse_q;
    logic             wrap;

    assign wrap = (state_q == ST_RUN) && tick && (count_q == period);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (swrst_stb)      state_d = ST_IDLE;
                else if (start_stb) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (swrst_stb)          state_d = ST_IDLE;
                else if (start_stb)     state_d = ST_RUN;
                else if (wrap && !cont) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            if (swrst_stb || start_stb) begin
                count_q <= '0;
            end else if (state_q == ST_RUN && tick) begin
                if (wrap) begin
                    count_q <= '0;
                    pulse_q <= 1'b1;
                end else begin
                    count_q <= count_q + CNT_W'(1);
                end
            end
        end
    end

    assign count_o   = count_q;
    assign running_o = (state_q == ST_RUN);
    assign pulse_o   = pulse_q;
endmodule

// File: rtl/pit64_timer.sv
module pit64_timer
    import pit64_pkg::*;
#(
    parameter int unsigned ADDR_W  = 8,
    parameter int unsigned PRESC_W = 4,
    localparam int unsigned CNT_W  = 2 * WORD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              period_pulse
);
    logic               start_stb;
    logic               swrst_stb;
    logic               cont;
    logic [PRESC_W-1:0] div;
    logic [CNT_W-1:0]   period;
    logic [CNT_W-1:0]   count;
    logic               running;
    logic               tick;

    pit64_regs #(.ADDR_W(ADDR_W), .PRESC_W(PRESC_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .count_i(count), .rdata(rdata),
        .start_stb(start_stb), .swrst_stb(swrst_stb),
        .cont_o(cont), .div_o(div), .period_o(period)
    );

    pit64_prescaler #(.PRESC_W(PRESC_W)) presc_i (
        .clk(clk), .rst_n(rst_n), .clr(start_stb || swrst_stb),
        .en(running), .div(div), .tick(tick)
    );

    pit64_core #(.CNT_W(CNT_W)) core_i (
        .clk(clk), .rst_n(rst_n), .start_stb(start_stb),
        .swrst_stb(swrst_stb), .tick(tick), .cont(cont),
        .period(period), .count_o(count), .running_o(running),
        .pulse_o(period_pulse)
    );
endmodule

// File: rtl/pit64_checker.sv
module pit64_checker #(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned CNT_W  = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       rdata,
    input logic              start_stb,
    input logic              swrst_stb,
    input logic              running,
    input logic              tick,
    input logic              cont,
    input logic [CNT_W-1:0]  period,
    input logic [CNT_W-1:0]  count,
    input logic              pulse
);
    logic quiet;
    assign quiet = !start_stb && !swrst_stb;

    AST_START_FROM_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (start_stb && !swrst_stb) |=> (running && count == '0)); // R2

    AST_HOLD_BETWEEN_TICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (running && !tick && quiet) |=> $stable(count)); // R3

    AST_CONT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && count == period && cont && quiet) |=> (running && count == '0 && pulse)); // R4

    AST_ONESHOT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && count == period && !cont && quiet) |=> (!running && count == '0)); // R5

    AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && quiet) |=> (!running && $stable(count))); // R5

    AST_PULSE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (count == '0 && $past(running && tick))); // R6

    AST_SWRST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        swrst_stb |=> (!running && count == '0 && period == '0)); // R7

    AST_CTRL_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == '0) |=> (rdata == '0)); // R8
endmodule

bind pit64_timer pit64_checker #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .addr(addr), .rdata(rdata),
    .start_stb(start_stb), .swrst_stb(swrst_stb), .running(running),
    .tick(tick), .cont(cont), .period(period), .count(count),
    .pulse(period_pulse)
);

// File: tb/pit64_timer_tb.sv
module pit64_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        period_pulse;

    int n_cmp = 0;
    int n_bad = 0;
    int ecount = 0;
    int t0 = 0;
    bit done = 1'b0;
    bit rd_seen = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    pit64_timer dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .period_pulse(period_pulse)
    );

    always @(posedge clk) begin
        ecount  <= ecount + 1;
        rd_seen <= rd_en;
    end

    // monitor: pops the expected read data once the design returns it
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            n_cmp++;
            if (rdata !== e) begin
                n_bad++;
                $display("FAIL %s: rdata actual %h expected %h", t, rdata, e);
            end
        end
    end

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic bus_read(input logic [7:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic start_timer();
        bus_write(8'h00, 32'h1);
        t0 = ecount;
    endtask

    task automatic wait_to(input int n);
        while (ecount - t0 < n) @(negedge clk);
    endtask

    task automatic check_pulse(input logic e, input string t);
        n_cmp++;
        if (period_pulse !== e) begin
            n_bad++;
            $display("FAIL %s: period_pulse actual %b expected %b", t, period_pulse, e);
        end
    endtask

    function automatic logic [31:0] exp_cnt(input int n, input int d, input int p, input bit cont);
        int t;
        t = n / (d + 1);
        if (cont) return 32'(t % (p + 1));
        return (t > p) ? 32'd0 : 32'(t);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check_pulse(1'b0, "R1 pulse after reset");
        bus_read(8'h00, 32'h0, "R1 ctrl");
        bus_read(8'h04, 32'h0, "R1 mode");
        bus_read(8'h08, 32'h0, "R1 per_lo");
        bus_read(8'h0C, 32'h0, "R1 per_hi");
        bus_read(8'h20, 32'h0, "R1 cnt_lo");
        bus_read(8'h24, 32'h0, "R1 cnt_hi");

        // R4 R6 continuous, div 0, period 5
        bus_write(8'h04, 32'h1);
        bus_write(8'h08, 32'd5);
        bus_read(8'h04, 32'h1, "R3 mode readback");
        bus_read(8'h08, 32'd5, "R9 per_lo readback");
        start_timer();
        wait_to(3);
        bus_read(8'h20, exp_cnt(ecount - t0, 0, 5, 1), "R2 count after start");
        wait_to(11);
        check_pulse(1'b0, "R6 before wrap");
        wait_to(12);
        check_pulse(1'b1, "R6 at wrap");
        bus_read(8'h20, exp_cnt(ecount - t0, 0, 5, 1), "R4 count after wrap");
        check_pulse(1'b0, "R6 one cycle only");
        bus_read(8'h20, exp_cnt(ecount - t0, 0, 5, 1), "R4 counting on");
        bus_read(8'h24, 32'h0, "R9 cnt_hi live");

        // R3 prescaler divide 3, R10 period change mid-run
        bus_write(8'h00, 32'h100);
        bus_write(8'h04, 32'h201);
        bus_write(8'h08, 32'd100);
        bus_read(8'h04, 32'h201, "R3 div field readback");
        start_timer();
        wait_to(7);
        bus_read(8'h20, exp_cnt(ecount - t0, 2, 100, 1), "R3 div3 n7");
        bus_read(8'h20, exp_cnt(ecount - t0, 2, 100, 1), "R3 div3 n8");
        bus_read(8'h20, exp_cnt(ecount - t0, 2, 100, 1), "R3 div3 n9");
        wait_to(20);
        bus_read(8'h20, exp_cnt(ecount - t0, 2, 100, 1), "R3 div3 n20");
        bus_write(8'h08, 32'd10);
        wait_to(34);
        bus_read(8'h20, exp_cnt(ecount - t0, 2, 10, 1), "R10 wrap at new period");
        wait_to(36);
        bus_read(8'h20, exp_cnt(ecount - t0, 2, 10, 1), "R10 after new wrap");

        // R11 restart while running
        start_timer();
        wait_to(4);
        bus_read(8'h20, exp_cnt(ecount - t0, 2, 10, 1), "R11 restart from zero");

        // R7 software reset clears configuration
        bus_write(8'h00, 32'h100);
        bus_read(8'h04, 32'h0, "R7 mode cleared");
        bus_read(8'h08, 32'h0, "R7 period cleared");
        bus_read(8'h20, 32'h0, "R7 count cleared");

        // R5 one-shot, div 2, period 3
        bus_write(8'h04, 32'h100);
        bus_write(8'h08, 32'd3);
        start_timer();
        wait_to(6);
        bus_read(8'h20, exp_cnt(ecount - t0, 1, 3, 0), "R5 before wrap");
        wait_to(8);
        check_pulse(1'b1, "R6 one-shot wrap");
        wait_to(9);
        check_pulse(1'b0, "R6 one-shot pulse ends");
        wait_to(10);
        bus_read(8'h20, 32'h0, "R5 stopped at zero");
        wait_to(20);
        bus_read(8'h20, 32'h0, "R5 still stopped");
        start_timer();
        wait_to(2);
        bus_read(8'h20, exp_cnt(ecount - t0, 1, 3, 0), "R5 restart counts");

        // R7 software reset beats start in the same write
        bus_write(8'h00, 32'h101);
        repeat (5) @(negedge clk);
        bus_read(8'h20, 32'h0, "R7 swrst wins over start");
        bus_read(8'h04, 32'h0, "R7 mode zero after combined write");

        // R8 R9 control, unmapped and counter offsets
        bus_write(8'h08, 32'd7);
        bus_write(8'h0C, 32'hA5A5_0001);
        bus_read(8'h0C, 32'hA5A5_0001, "R9 per_hi readback");
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h20, 32'h0000_0055);
        bus_write(8'h24, 32'h0000_0066);
        bus_read(8'h10, 32'h0, "R8 unmapped read");
        bus_read(8'h14, 32'h0, "R8 unmapped read 2");
        bus_read(8'h20, 32'h0, "R8 counter write ignored");
        bus_read(8'h24, 32'h0, "R8 counter hi write ignored");
        bus_read(8'h08, 32'd7, "R8 per_lo untouched");
        bus_read(8'h04, 32'h0, "R8 mode untouched");
        bus_read(8'h00, 32'h0, "R8 ctrl reads zero");
        repeat (2) @(negedge clk);

        if (exp_q.size() != 0) begin
            n_bad++;
            $display("FAIL R9: pending reads actual %0d expected 0", exp_q.size());
        end
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule